// File: doc/BRIEF.md
# Link Controller Interrupt Status and Enable Registers

This block holds the interrupt state of a link controller in two byte-wide host registers. One records which events have happened. The other selects which of those events may interrupt the host. Five event sources feed the status register, and each one arrives as a single-cycle pulse:

- transmit complete
- receive complete
- transmit underrun
- receive overflow
- serial gap detected

A transmit-complete pulse comes with a qualifier. The qualifier tells whether the finished transmit slot asked to be reported.

The host reads both registers through a simple address/write port. It acknowledges events by writing ones to the status register. It arms sources by writing the enable register. The block drives one level-sensitive interrupt line. That line is high while any armed source has a pending status bit. Status bits record events whether or not they are armed, so a source that is armed later raises the line at once if its event is already pending.

Top module: `link_irq_ctrl`

## Requirements
- R1: After a synchronous reset all five status bits and all five enable bits are 0, and the interrupt output is low.
- R2: The status register is at address 0x0C and the enable register at 0x0D. Any other address reads 0x00, and a write to it changes neither register.
- R3: In both registers the source bits sit at these positions: bit 7 transmit complete, bit 6 receive complete, bit 5 transmit underrun, bit 4 receive overflow, bit 3 serial gap. An event pulse sets its status bit from the next clock edge on.
- R4: Bits 2..0 of both registers always read as 1, whatever value was written.
- R5: A write to the enable register loads bits 7..3 of the write data. A 1 arms the source and a 0 disarms it.
- R6: In a write to the status register, each 1 in bits 7..3 clears that status bit and each 0 leaves it unchanged.
- R7: A transmit-complete pulse sets status bit 7 only when the slot-request qualifier is high in the same cycle. Without the qualifier it has no effect.
- R8: The interrupt output is high exactly when some bit among 7..3 is set in both the status and the enable register. It is a combinational function of the two registers.
- R9: When an event pulse and a write-1 clear hit the same status bit in the same cycle, the bit ends up set.
- R10: Status bits latch while their source is disarmed. Arming a source whose bit is pending raises the interrupt right after the enable write's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | ADDR_W | Register address for read and write |
| host_wr | input | 1 | Write strobe, one cycle per write |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for host_addr, combinational |
| ev_tx_done | input | 1 | Transmit-complete pulse |
| ev_tx_req | input | 1 | Qualifier: the completed slot requested reporting |
| ev_rx_done | input | 1 | Receive-complete pulse |
| ev_tx_under | input | 1 | Transmit-underrun pulse |
| ev_rx_over | input | 1 | Receive-overflow pulse |
| ev_gap | input | 1 | Serial-gap pulse |
| irq | output | 1 | Level interrupt request |

## Verification
The bench uses the default parameters: a 5-bit address, status at 0x0C and enable at 0x0D. With these values both registers and an unused address such as 0x00 can be reached, so address decoding is exercised on the ports. Each source is pulsed on its own and the bit that appears is checked against the stated layout. The bench then covers a transmit completion without its qualifier, a clear that coincides with an event, and enabling a source whose bit was latched earlier. Every expected read value and interrupt level comes from a register model kept inside the bench.

// File: rtl/link_irq_pkg.sv
package link_irq_pkg;
    localparam int REG_W   = 8;
    localparam int NUM_SRC = 5;
    localparam int PAD_W   = REG_W - NUM_SRC;

    // Field order matches the register bits 7..3.
    typedef struct packed {
        logic tx_done;
        logic rx_done;
        logic tx_under;
        logic rx_over;
        logic gap;
    } irq_src_t;

    function automatic logic [REG_W-1:0] to_reg_byte(irq_src_t v);
        return {v, {PAD_W{1'b1}}};
    endfunction

    function automatic irq_src_t from_reg_byte(logic [REG_W-1:0] b);
        return irq_src_t'(b[REG_W-1:PAD_W]);
    endfunction
endpackage

// File: rtl/irq_event_qual.sv
module irq_event_qual
    import link_irq_pkg::*;
(
    input  logic     tx_done_i,
    input  logic     tx_req_i,
    input  logic     rx_done_i,
    input  logic     tx_under_i,
    input  logic     rx_over_i,
    input  logic     gap_i,
    output irq_src_t set_o
);
    always_comb begin
        set_o          = '0;
        set_o.tx_done  = tx_done_i & tx_req_i;
        set_o.rx_done  = rx_done_i;
        set_o.tx_under = tx_under_i;
        set_o.rx_over  = rx_over_i;
        set_o.gap      = gap_i;
    end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
    import link_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  irq_src_t set_i,
    input  irq_src_t clr_i,
    output irq_src_t status_o
);
    logic [NUM_SRC-1:0] set_v;
    logic [NUM_SRC-1:0] clr_v;
    logic [NUM_SRC-1:0] bits_q;

    assign set_v = set_i;
    assign clr_v = clr_i;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                bits_q[i] <= 1'b0;
            else if (set_v[i])
                bits_q[i] <= 1'b1;   // a new event beats a same-cycle clear
            else if (clr_v[i])
                bits_q[i] <= 1'b0;
        end
    end

    assign status_o = irq_src_t'(bits_q);
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg
    import link_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     we_i,
    input  irq_src_t wdata_i,
    output irq_src_t enable_o
);
    always_ff @(posedge clk) begin
        if (rst)
            enable_o <= '0;
        else if (we_i)
            enable_o <= wdata_i;
    end
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
    import link_irq_pkg::*;
#(
    parameter int                ADDR_W   = 5,
    parameter logic [ADDR_W-1:0] STAT_OFS = 5'h0C,
    parameter logic [ADDR_W-1:0] EN_OFS   = 5'h0D
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  irq_src_t          status_i,
    input  irq_src_t          enable_i,
    output logic [REG_W-1:0]  rdata_o,
    output logic              irq_o
);
    always_comb begin
        if (addr_i == STAT_OFS)
            rdata_o = to_reg_byte(status_i);
        else if (addr_i == EN_OFS)
            rdata_o = to_reg_byte(enable_i);
        else
            rdata_o = '0;
    end

    assign irq_o = |(status_i & enable_i);
endmodule

// File: rtl/link_irq_ctrl.sv
module link_irq_ctrl
    import link_irq_pkg::*;
#(
    parameter int                ADDR_W   = 5,
    parameter logic [ADDR_W-1:0] STAT_OFS = 5'h0C,
    parameter logic [ADDR_W-1:0] EN_OFS   = 5'h0D
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic              ev_tx_done,
    input  logic              ev_tx_req,
    input  logic              ev_rx_done,
    input  logic              ev_tx_under,
    input  logic              ev_rx_over,
    input  logic              ev_gap,
    output logic              irq
);
    irq_src_t set_vec;
    irq_src_t clr_vec;
    irq_src_t status_s;
    irq_src_t enable_s;
    logic     stat_we;
    logic     en_we;
    logic [NUM_SRC-1:0] status_q;
    logic [NUM_SRC-1:0] enable_q;

    assign stat_we = host_wr && (host_addr == STAT_OFS);
    assign en_we   = host_wr && (host_addr == EN_OFS);
    assign clr_vec = stat_we ? from_reg_byte(host_wdata) : '0;

    irq_event_qual u_qual (
        .tx_done_i  (ev_tx_done),
        .tx_req_i   (ev_tx_req),
        .rx_done_i  (ev_rx_done),
        .tx_under_i (ev_tx_under),
        .rx_over_i  (ev_rx_over),
        .gap_i      (ev_gap),
        .set_o      (set_vec)
    );

    irq_status_bank u_status (
        .clk      (clk),
        .rst      (rst),
        .set_i    (set_vec),
        .clr_i    (clr_vec),
        .status_o (status_s)
    );

    irq_enable_reg u_enable (
        .clk      (clk),
        .rst      (rst),
        .we_i     (en_we),
        .wdata_i  (from_reg_byte(host_wdata)),
        .enable_o (enable_s)
    );

    irq_read_mux #(
        .ADDR_W   (ADDR_W),
        .STAT_OFS (STAT_OFS),
        .EN_OFS   (EN_OFS)
    ) u_rmux (
        .addr_i   (host_addr),
        .status_i (status_s),
        .enable_i (enable_s),
        .rdata_o  (host_rdata),
        .irq_o    (irq)
    );

    assign status_q = status_s;
    assign enable_q = enable_s;
endmodule

// File: rtl/link_irq_ctrl_chk.sv
module link_irq_ctrl_chk #(
    parameter int                ADDR_W   = 5,
    parameter logic [ADDR_W-1:0] STAT_OFS = 5'h0C,
    parameter logic [ADDR_W-1:0] EN_OFS   = 5'h0D
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] host_addr,
    input logic              host_wr,
    input logic [7:0]        host_wdata,
    input logic [7:0]        host_rdata,
    input logic              ev_tx_done,
    input logic              ev_tx_req,
    input logic              ev_rx_done,
    input logic              ev_tx_under,
    input logic              irq,
    input logic [4:0]        status_q,
    input logic [4:0]        enable_q
);
    p_rst_clear_r1: assert property (@(posedge clk)
        rst |=> (status_q == 5'd0 && enable_q == 5'd0));

    p_other_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (host_addr != STAT_OFS && host_addr != EN_OFS) |-> host_rdata == 8'h00);

    p_rx_sets_r3: assert property (@(posedge clk) disable iff (rst)
        ev_rx_done |=> status_q[3]);

    p_low_ones_r4: assert property (@(posedge clk) disable iff (rst)
        (host_addr == STAT_OFS || host_addr == EN_OFS) |-> host_rdata[2:0] == 3'b111);

    p_en_load_r5: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr == EN_OFS) |=> enable_q == $past(host_wdata[7:3]));

    p_w1c_r6: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr == STAT_OFS && host_wdata[6] && !ev_rx_done) |=> !status_q[3]);

    p_zero_keeps_r6: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr == STAT_OFS && !host_wdata[4] && status_q[1]) |=> status_q[1]);

    p_tx_gate_r7: assert property (@(posedge clk) disable iff (rst)
        (!status_q[4] && !(ev_tx_done && ev_tx_req)) |=> !status_q[4]);

    p_no_irq_r8: assert property (@(posedge clk) disable iff (rst)
        (enable_q == 5'd0) |-> !irq);

    p_event_wins_r9: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr == STAT_OFS && host_wdata[5] && ev_tx_under) |=> status_q[2]);

    p_late_enable_r10: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr == EN_OFS && host_wdata[7] && status_q[4]) |=> irq);
endmodule

bind link_irq_ctrl link_irq_ctrl_chk #(
    .ADDR_W   (ADDR_W),
    .STAT_OFS (STAT_OFS),
    .EN_OFS   (EN_OFS)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .host_addr   (host_addr),
    .host_wr     (host_wr),
    .host_wdata  (host_wdata),
    .host_rdata  (host_rdata),
    .ev_tx_done  (ev_tx_done),
    .ev_tx_req   (ev_tx_req),
    .ev_rx_done  (ev_rx_done),
    .ev_tx_under (ev_tx_under),
    .irq         (irq),
    .status_q    (status_q),
    .enable_q    (enable_q)
);

// File: tb/test_link_irq_ctrl.sv
`timescale 1ns/1ps
module test_link_irq_ctrl;
    localparam int          ADDR_W = 5;
    localparam logic [4:0]  A_STAT = 5'h0C;
    localparam logic [4:0]  A_EN   = 5'h0D;
    localparam logic [4:0]  A_NONE = 5'h00;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [ADDR_W-1:0] host_addr = '0;
    logic             host_wr = 1'b0;
    logic [7:0]       host_wdata = '0;
    logic [7:0]       host_rdata;
    logic             ev_tx_done = 1'b0;
    logic             ev_tx_req = 1'b0;
    logic             ev_rx_done = 1'b0;
    logic             ev_tx_under = 1'b0;
    logic             ev_rx_over = 1'b0;
    logic             ev_gap = 1'b0;
    logic             irq;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    // bench model of the two registers (bits 7..3 only)
    logic [4:0] m_stat = '0;
    logic [4:0] m_en   = '0;

    logic [7:0] q_rd[$];
    logic       q_irq[$];
    string      q_tag[$];
    event       mon_ev;

    always #4 clk = ~clk;   // 125 MHz

    link_irq_ctrl i_link_irq_ctrl (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .ev_tx_done(ev_tx_done), .ev_tx_req(ev_tx_req), .ev_rx_done(ev_rx_done),
        .ev_tx_under(ev_tx_under), .ev_rx_over(ev_rx_over), .ev_gap(ev_gap),
        .irq(irq)
    );

    // monitor: pops expected items and compares with the design
    initial begin
        forever begin
            @(mon_ev);
            #1;
            if (q_rd.size() > 0) begin
                logic [7:0] e_rd;
                logic       e_irq;
                string      tg;
                e_rd  = q_rd.pop_front();
                e_irq = q_irq.pop_front();
                tg    = q_tag.pop_front();
                checks++;
                if (host_rdata !== e_rd || irq !== e_irq) begin
                    fails++;
                    $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                             tg, host_rdata, irq, e_rd, e_irq);
                end
            end
        end
    end

    function automatic logic [7:0] exp_byte(logic [4:0] addr);
        if (addr == A_STAT) return {m_stat, 3'b111};
        if (addr == A_EN)   return {m_en, 3'b111};
        return 8'h00;
    endfunction

    task automatic check_reg(input logic [4:0] addr, input string tag);
        @(negedge clk);
        host_addr = addr;
        q_rd.push_back(exp_byte(addr));
        q_irq.push_back(|(m_stat & m_en));
        q_tag.push_back(tag);
        -> mon_ev;
        #2;
    endtask

    task automatic host_write(input logic [4:0] addr, input logic [7:0] d);
        @(negedge clk);
        host_addr  = addr;
        host_wdata = d;
        host_wr    = 1'b1;
        if (addr == A_STAT) m_stat = m_stat & ~d[7:3];
        if (addr == A_EN)   m_en   = d[7:3];
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    // pulse vector bits: [4]tx_done [3]rx_done [2]tx_under [1]rx_over [0]gap
    task automatic pulse(input logic [4:0] v, input logic req);
        @(negedge clk);
        {ev_tx_done, ev_rx_done, ev_tx_under, ev_rx_over, ev_gap} = v;
        ev_tx_req = req;
        m_stat = m_stat | {v[4] & req, v[3:0]};
        @(negedge clk);
        {ev_tx_done, ev_rx_done, ev_tx_under, ev_rx_over, ev_gap} = '0;
        ev_tx_req = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 and R4: reset values, padding bits read as ones
        check_reg(A_STAT, "R1 status after reset");
        check_reg(A_EN,   "R1 enable after reset");
        // R2: unused address
        check_reg(A_NONE, "R2 unused address reads zero");

        // R3: each source lands on its own bit
        pulse(5'b10000, 1'b1); check_reg(A_STAT, "R3 tx done bit7");
        host_write(A_STAT, 8'hF8);
        pulse(5'b01000, 1'b0); check_reg(A_STAT, "R3 rx done bit6");
        host_write(A_STAT, 8'hF8);
        pulse(5'b00100, 1'b0); check_reg(A_STAT, "R3 tx underrun bit5");
        host_write(A_STAT, 8'hF8);
        pulse(5'b00010, 1'b0); check_reg(A_STAT, "R3 rx overflow bit4");
        host_write(A_STAT, 8'hF8);
        pulse(5'b00001, 1'b0); check_reg(A_STAT, "R3 serial gap bit3");
        host_write(A_STAT, 8'hF8);
        check_reg(A_STAT, "R6 clear all");

        // R7: tx done without qualifier ignored
        pulse(5'b10000, 1'b0); check_reg(A_STAT, "R7 tx done without request");

        // R4: writing zeros to low bits of enable
        host_write(A_EN, 8'h00); check_reg(A_EN, "R4 enable low bits read one");
        // R5: enable load
        host_write(A_EN, 8'h28); check_reg(A_EN, "R5 enable load 0x28");
        host_write(A_EN, 8'h00); check_reg(A_EN, "R5 enable cleared");

        // R10 and R8: latch while disabled, then arm
        pulse(5'b11000, 1'b1); check_reg(A_STAT, "R10 latched while disabled irq low");
        host_write(A_EN, 8'h40); check_reg(A_STAT, "R10 arming raises irq");
        check_reg(A_EN, "R8 irq with rx done armed");

        // R6: write zero keeps, write one clears
        host_write(A_STAT, 8'h00); check_reg(A_STAT, "R6 zero write keeps bits");
        host_write(A_STAT, 8'h40); check_reg(A_STAT, "R6 clear rx done drops irq");

        // R2: write to unused address changes nothing
        host_write(A_NONE, 8'hFF); check_reg(A_STAT, "R2 unused write status");
        check_reg(A_EN, "R2 unused write enable");

        // R9: event and clear in the same cycle
        host_write(A_EN, 8'h20);
        @(negedge clk);
        host_addr = A_STAT; host_wdata = 8'h20; host_wr = 1'b1; ev_tx_under = 1'b1;
        m_stat = m_stat | 5'b00100;
        @(negedge clk);
        host_wr = 1'b0; ev_tx_under = 1'b0;
        check_reg(A_STAT, "R9 event wins over clear");

        // R8: multiple sources, disarmed ones do not count
        host_write(A_STAT, 8'hF8);
        pulse(5'b00011, 1'b0);
        check_reg(A_STAT, "R8 pending but not armed");
        host_write(A_EN, 8'h08); check_reg(A_STAT, "R8 gap armed irq high");

        // R1: reset again clears everything
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        m_stat = '0; m_en = '0;
        check_reg(A_STAT, "R1 status after second reset");
        check_reg(A_EN,   "R1 enable after second reset");

        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule